// File: doc/BRIEF.md
# Single-Cycle Load/Store/Branch Core

This block is a small single-cycle processor core. Every clock it fetches one 32-bit instruction from its own instruction memory, decodes it, runs it through one shared ALU and retires it. It handles register-to-register arithmetic and logic, word loads, word stores and a branch taken when two registers are equal. Instruction memory and data memory are separate arrays inside the block. A dedicated adder steps the program counter, and a second adder forms branch targets.

A preload port fills either memory one word at a time. It is intended for use while reset is held. The write bus to the register file and the write bus to data memory are brought out as outputs, together with the current PC and instruction, so the effect of each retired instruction can be seen at the ports.

Top module: `sc_ldst_core`

## Requirements
- R1: Reset is synchronous and active high. A rising edge with `rst` high sets the PC to 0. While `rst` is high, neither the register file nor data memory is written.
- R2: Any instruction other than a taken branch loads PC+4 into the PC at the next edge. This includes a branch (opcode 0x04) whose registers differ.
- R3: A branch (opcode 0x04; rs in bits 25-21, rt in bits 20-16) with rs equal to rt loads PC+4 plus the sign-extended 16-bit displacement shifted left by two. Negative displacements jump backwards.
- R4: With opcode 0x00, funct (bits 5-0) 0x20, 0x22, 0x24, 0x25 and 0x2A select add, subtract, AND, OR and signed set-less-than (result 1 or 0) of rs and rt. The result is written to rd (bits 15-11).
- R5: A load (opcode 0x23) writes the data-memory word at byte address rs + sign-extended bits 15-0 into rt (bits 20-16).
- R6: A store (opcode 0x2B) writes rt to data memory. The byte address rs + sign-extended displacement appears unshifted on `mem_addr_o`. No other instruction asserts `mem_we_o`.
- R7: Register 0 always reads as zero. A write aimed at it does not reach the register file and does not assert `reg_we_o`.
- R8: An unlisted opcode, or opcode 0x00 with an unlisted funct, writes neither registers nor memory and advances the PC by 4.
- R9: A value written by one instruction is seen by the next instruction that reads it. This holds for registers and for data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe |
| load_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| load_addr | input | 32 | Preload byte address (word aligned) |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| reg_we_o | output | 1 | Register file write this cycle |
| reg_waddr_o | output | 5 | Register number written |
| reg_wdata_o | output | 32 | Value written to the register |
| mem_we_o | output | 1 | Data memory write this cycle |
| mem_addr_o | output | 32 | Data memory byte address (ALU result) |
| mem_wdata_o | output | 32 | Data memory write value |

## Verification
ALU operands are a negative word and a positive word whose bit patterns overlap in part. This single pair tells add from subtract, AND from OR, and signed from unsigned compare, with the compare tried in both orders. Stores and loads use a positive base with a negative displacement, which exposes missing sign extension or an address shifted by mistake. A load that follows a store to the same address shows that memory updates are visible at once. Branch programs hold a taken forward branch, a branch that is not taken and a taken backward branch, so the next-PC multiplexer is checked for both selections and for both signs of displacement. Writes aimed at register 0 and undefined encodings check that nothing changes state.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);

    localparam logic [5:0] OP_ALU   = 6'h00;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic [5:0]        opcode;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    typedef struct packed {
        logic    dst_from_rd;   // write register from rd, else rt
        logic    b_from_imm;    // ALU operand B from immediate, else rt
        logic    wb_from_mem;   // write data from memory, else ALU
        logic    reg_write;
        logic    mem_write;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  instr_t ins,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (ins.opcode)
            OP_ALU: begin
                ctrl.dst_from_rd = 1'b1;
                ctrl.reg_write   = 1'b1;
                case (ins.funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctrl.b_from_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
            end
            OP_STORE: begin
                ctrl.b_from_imm = 1'b1;
                ctrl.mem_write  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr_a,
    output logic [WIDTH-1:0]         rdata_a,
    input  logic [$clog2(DEPTH)-1:0] raddr_b,
    output logic [WIDTH-1:0]         rdata_b
);

    logic [WIDTH-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_ldst_core.sv
module sc_ldst_core
    import core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load_en,
    input  logic        load_dmem,
    input  logic [31:0] load_addr,
    input  logic [31:0] load_data,
    output logic [31:0] pc_o,
    output logic [31:0] instr_o,
    output logic        reg_we_o,
    output logic [4:0]  reg_waddr_o,
    output logic [31:0] reg_wdata_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0]   pc_q, pc_seq, pc_br, pc_next;
    instr_t            ins;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y, mem_rd, wb_val;
    logic              alu_zero, take_br, rf_we, dm_we;
    logic [RIDX_W-1:0] wreg;
    logic              unused_bits;

    // fetch and program counter
    assign ins     = imem[pc_q[IAW+1:2]];
    assign pc_seq  = pc_q + 32'd4;
    assign pc_br   = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
    assign take_br = ctrl.branch & alu_zero;
    assign pc_next = take_br ? pc_br : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    core_decode u_dec (
        .ins  (ins),
        .ctrl (ctrl)
    );

    // operand selection and execute
    assign wreg    = ctrl.dst_from_rd ? ins.rd : ins.rt;
    assign imm_ext = sext16({ins.rd, ins.shamt, ins.funct});
    assign alu_b   = ctrl.b_from_imm ? imm_ext : rt_val;
    assign rf_we   = ctrl.reg_write & ~rst;

    core_regfile #(
        .DEPTH (NREGS),
        .WIDTH (XLEN)
    ) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (wreg),
        .wdata   (wb_val),
        .raddr_a (ins.rs),
        .rdata_a (rs_val),
        .raddr_b (ins.rt),
        .rdata_b (rt_val)
    );

    core_alu #(
        .WIDTH (XLEN)
    ) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory and write-back
    assign dm_we  = ctrl.mem_write & ~rst;
    assign mem_rd = dmem[alu_y[DAW+1:2]];
    assign wb_val = ctrl.wb_from_mem ? mem_rd : alu_y;

    always_ff @(posedge clk) begin
        if (load_en && load_dmem) begin
            dmem[load_addr[DAW+1:2]] <= load_data;
        end else if (dm_we) begin
            dmem[alu_y[DAW+1:2]] <= rt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (load_en && !load_dmem) begin
            imem[load_addr[IAW+1:2]] <= load_data;
        end
    end

    assign pc_o        = pc_q;
    assign instr_o     = ins;
    assign reg_we_o    = rf_we & (wreg != '0);
    assign reg_waddr_o = wreg;
    assign reg_wdata_o = wb_val;
    assign mem_we_o    = dm_we;
    assign mem_addr_o  = alu_y;
    assign mem_wdata_o = rt_val;

    assign unused_bits = ^{load_addr, ins.shamt};

endmodule

// File: rtl/sc_ldst_props.sv
module sc_ldst_props
    import core_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr_o,
    input logic        reg_we_o,
    input logic [4:0]  reg_waddr_o,
    input logic [31:0] reg_wdata_o,
    input logic        mem_we_o
);

    logic [5:0]  opc;
    logic [31:0] br_off;
    logic        known_op;

    assign opc    = instr_o[31:26];
    assign br_off = {sext16(instr_o[15:0]), 2'b00};
    assign known_op = (opc == OP_LOAD) || (opc == OP_STORE) || (opc == OP_BEQ) ||
                      ((opc == OP_ALU) && ((instr_o[5:0] == FN_ADD) || (instr_o[5:0] == FN_SUB) ||
                        (instr_o[5:0] == FN_AND) || (instr_o[5:0] == FN_OR) ||
                        (instr_o[5:0] == FN_SLT)));

    // R1
    a_r1_pc_clear: assert property (@(posedge clk) rst |=> pc_o == 32'd0);
    a_r1_no_write: assert property (@(posedge clk) rst |-> !reg_we_o && !mem_we_o);

    // R2
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        opc != OP_BEQ |=> pc_o == $past(pc_o) + 32'd4);

    // R3
    a_r3_branch_dest: assert property (@(posedge clk) disable iff (rst)
        opc == OP_BEQ |=> (pc_o == $past(pc_o) + 32'd4) ||
                          (pc_o == $past(pc_o) + 32'd4 + $past(br_off)));

    // R4
    a_r4_rtype_dest: assert property (@(posedge clk) disable iff (rst)
        reg_we_o && opc == OP_ALU |-> reg_waddr_o == instr_o[15:11]);

    // R5
    a_r5_load_dest: assert property (@(posedge clk) disable iff (rst)
        reg_we_o && opc == OP_LOAD |-> reg_waddr_o == instr_o[20:16]);

    // R6
    a_r6_store_only: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> opc == OP_STORE);

    // R7
    a_r7_zero_dest: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |-> reg_waddr_o != 5'd0);
    a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
        opc == OP_ALU && instr_o[5:0] == FN_ADD && instr_o[25:16] == 10'd0 |->
        reg_wdata_o == 32'd0);

    // R8
    a_r8_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> !reg_we_o && !mem_we_o);

endmodule

bind sc_ldst_core sc_ldst_props u_props (
    .clk         (clk),
    .rst         (rst),
    .pc_o        (pc_o),
    .instr_o     (instr_o),
    .reg_we_o    (reg_we_o),
    .reg_waddr_o (reg_waddr_o),
    .reg_wdata_o (reg_wdata_o),
    .mem_we_o    (mem_we_o)
);

// File: tb/tb_sc_ldst_core.sv
`timescale 1ns/1ps
module tb_sc_ldst_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_dmem = 1'b0;
    logic [31:0] load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o, instr_o, reg_wdata_o, mem_addr_o, mem_wdata_o;
    logic        reg_we_o, mem_we_o;
    logic [4:0]  reg_waddr_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] prog [16];
    logic [31:0] dm   [8];

    always #4 clk = ~clk;

    sc_ldst_core dut (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .load_dmem   (load_dmem),
        .load_addr   (load_addr),
        .load_data   (load_data),
        .pc_o        (pc_o),
        .instr_o     (instr_o),
        .reg_we_o    (reg_we_o),
        .reg_waddr_o (reg_waddr_o),
        .reg_wdata_o (reg_wdata_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic to_dmem, input int idx, input logic [31:0] d);
        @(negedge clk);
        load_en   = 1'b1;
        load_dmem = to_dmem;
        load_addr = 32'(idx * 4);
        load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = '0;
        for (int i = 0; i < 8; i++) dm[i] = '0;
    endtask

    // hold reset, load both memories, release; leaves time just after release
    task automatic boot();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) put_word(1'b0, i, prog[i]);
        for (int i = 0; i < 8; i++) put_word(1'b1, i, dm[i]);
        #1;
        chk("R1 pc under reset", pc_o, 32'd0);
        chk("R1 no reg write under reset", {31'd0, reg_we_o}, 32'd0);
        chk("R1 no mem write under reset", {31'd0, mem_we_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic adv();
        @(negedge clk);
        #1;
    endtask

    task automatic chk_rw(input string req, input logic [4:0] a, input logic [31:0] d);
        chk({req, " reg we"}, {31'd0, reg_we_o}, 32'd1);
        chk({req, " reg addr"}, {27'd0, reg_waddr_o}, {27'd0, a});
        chk({req, " reg data"}, reg_wdata_o, d);
    endtask

    task automatic test_alu();
        clear_prog();
        dm[0] = 32'hFFFF_FFFD;
        dm[1] = 32'h0000_0F0E;
        prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
        prog[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
        prog[2] = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
        prog[3] = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
        prog[4] = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
        prog[5] = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
        prog[6] = enc_r(5'd1, 5'd2, 5'd7, 6'h2A);
        prog[7] = enc_r(5'd2, 5'd1, 5'd8, 6'h2A);
        prog[8] = enc_i(6'h2B, 5'd0, 5'd3, 16'd8);
        boot();
        chk_rw("R5 load r1", 5'd1, 32'hFFFF_FFFD);          adv();
        chk_rw("R5 load r2", 5'd2, 32'h0000_0F0E);          adv();
        chk_rw("R4 add", 5'd3, 32'h0000_0F0B);              adv();
        chk_rw("R4 sub", 5'd4, 32'hFFFF_F0EF);              adv();
        chk_rw("R4 and", 5'd5, 32'h0000_0F0C);              adv();
        chk_rw("R4 or", 5'd6, 32'hFFFF_FFFF);               adv();
        chk_rw("R4 slt neg<pos", 5'd7, 32'd1);              adv();
        chk_rw("R4 slt pos<neg", 5'd8, 32'd0);              adv();
        chk("R2 pc after eight", pc_o, 32'd32);
        chk("R9 store sees add result", mem_wdata_o, 32'h0000_0F0B);
        chk("R6 store address", mem_addr_o, 32'd8);
    endtask

    task automatic test_mem();
        clear_prog();
        dm[0] = 32'h1234_5678;
        dm[1] = 32'h0000_0020;
        prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
        prog[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
        prog[2] = enc_i(6'h2B, 5'd2, 5'd1, 16'hFFF8);
        prog[3] = enc_i(6'h23, 5'd2, 5'd5, 16'hFFF8);
        prog[4] = enc_i(6'h2B, 5'd0, 5'd0, 16'd12);
        boot();
        chk("R6 no store on load", {31'd0, mem_we_o}, 32'd0);
        adv();
        adv();
        chk("R6 store we", {31'd0, mem_we_o}, 32'd1);
        chk("R6 store byte addr unshifted, negative disp", mem_addr_o, 32'h0000_0018);
        chk("R6 store data", mem_wdata_o, 32'h1234_5678);
        chk("R6 store writes no register", {31'd0, reg_we_o}, 32'd0);
        adv();
        chk_rw("R9 load after store", 5'd5, 32'h1234_5678);
        adv();
        chk("R7 store of r0 is zero", mem_wdata_o, 32'd0);
        chk("R6 store addr r0 base", mem_addr_o, 32'd12);
    endtask

    task automatic test_zero_reg();
        clear_prog();
        dm[0] = 32'hAAAA_5555;
        prog[0] = enc_i(6'h23, 5'd0, 5'd0, 16'd0);
        prog[1] = enc_r(5'd0, 5'd0, 5'd3, 6'h20);
        prog[2] = enc_i(6'h2B, 5'd0, 5'd0, 16'd16);
        boot();
        chk("R7 load into r0 not written", {31'd0, reg_we_o}, 32'd0);
        adv();
        chk_rw("R7 r0 reads zero", 5'd3, 32'd0);
        adv();
        chk("R7 r0 still zero after load", mem_wdata_o, 32'd0);
    endtask

    task automatic test_branch();
        clear_prog();
        dm[0] = 32'd7;
        dm[1] = 32'd7;
        prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
        prog[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
        prog[2] = enc_i(6'h04, 5'd1, 5'd2, 16'd2);
        prog[3] = enc_r(5'd1, 5'd1, 5'd9, 6'h20);
        prog[4] = enc_r(5'd1, 5'd1, 5'd9, 6'h20);
        prog[5] = enc_i(6'h04, 5'd1, 5'd0, 16'd5);
        prog[6] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFF9);
        boot();
        adv();
        adv();
        chk("R2 pc at branch", pc_o, 32'd8);
        chk("R3 branch writes no register", {31'd0, reg_we_o}, 32'd0);
        adv();
        chk("R3 forward branch taken", pc_o, 32'd20);
        adv();
        chk("R2 unequal branch falls through", pc_o, 32'd24);
        adv();
        chk("R3 backward branch taken", pc_o, 32'd0);
    endtask

    task automatic test_unknown();
        clear_prog();
        prog[0] = enc_i(6'h3F, 5'd1, 5'd2, 16'h0008);
        prog[1] = enc_r(5'd1, 5'd1, 5'd3, 6'h27);
        boot();
        chk("R8 unknown opcode no reg write", {31'd0, reg_we_o}, 32'd0);
        chk("R8 unknown opcode no mem write", {31'd0, mem_we_o}, 32'd0);
        adv();
        chk("R8 unknown opcode pc step", pc_o, 32'd4);
        chk("R8 unknown funct no reg write", {31'd0, reg_we_o}, 32'd0);
        chk("R8 unknown funct no mem write", {31'd0, mem_we_o}, 32'd0);
        adv();
        chk("R8 unknown funct pc step", pc_o, 32'd8);
    endtask

    initial begin
        test_alu();
        test_mem();
        test_zero_reg();
        test_branch();
        test_unknown();
        test_alu();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule